// File: doc/BRIEF.md
# Ping-Pong De-Interleaving Buffer

This block sits behind the frame-sync and descrambling stage of a digital stereo sound decoder. Descrambled sound bits arrive one at a time with a valid qualifier. The block gathers them into a block of 64 words, each 11 bits wide. The transmitter sent each block column by column, so every incoming bit lands at a scattered word and bit position. Two storage banks take turns: one fills from the serial stream while the other is emptied.

The read side is paced by a strobe. Each accepted strobe returns one 11-bit word from the full bank. Words are not read in storage order: a fixed address permutation, computed by a constant function, sets the order. Every emitted word carries a channel ident (A or B) and a block-start marker. A frame resync throws away the block that is being filled. Reading then stalls once the completed blocks are used up.

Top module: `dilv_buffer`

## Requirements
- R1: While reset is asserted, and just after it is released, word_valid_o, block_start_o, ident_o and word_o are all 0.
- R2: Within a block, accepted bit number k (k = 0..703) is stored in word k mod 64, at bit position 10 - (k div 64). The first 64 bits are therefore the MSBs of words 0..63.
- R3: Read number j of a block (j = 0..63) returns stored word (j*37 + 11) mod 64.
- R4: A strobe that finds a complete bank produces exactly one word. word_valid_o is high for one cycle, in the cycle after the strobe edge, and word_o holds the word in that cycle.
- R5: block_start_o is high together with the first word read from each block, and with no other word.
- R6: ident_o is 0 (channel A) on even-numbered words of a block and 1 (channel B) on odd-numbered words.
- R7: After 704 accepted bits the filled bank becomes readable and writing moves to the other bank. Writing and reading may overlap, and blocks are read out in the order they were completed.
- R8: A strobe when no complete bank is waiting produces no word_valid_o, and word_o keeps its previous value.
- R9: resync_i discards the partly written block. Writing restarts at bit 0 of the same bank, and nothing from the discarded bits is ever read out.
- R10: While both banks hold unread complete blocks, incoming bits are dropped and do not advance the bit count.
- R11: bit_i is ignored in cycles where bit_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Qualifies bit_i |
| bit_i | input | 1 | Serial descrambled data bit |
| resync_i | input | 1 | Frame resync; discards the partial block |
| rd_strobe_i | input | 1 | Requests the next output word |
| word_o | output | 11 | De-interleaved output word |
| word_valid_o | output | 1 | word_o carries a new word this cycle |
| block_start_o | output | 1 | First word of a block |
| ident_o | output | 1 | Channel ident: 0 = A, 1 = B |

## Verification
Two events can fall in the same clock edge: the last bit of a block completing the write bank, and the 64th read strobe releasing the other bank. The bench streams a new block while it reads out the previous one. It delays the reader so that the final strobe lands on the same edge as bit 703. It then judges the result by reading the newly completed block in full, checking the words, idents and start marker, and checking that no third block appears.

// File: rtl/dilv_pkg.sv
package dilv_pkg;
  // read-order permutation; MULT must be odd so the map is a bijection mod DEPTH
  function automatic int unsigned perm_addr(int unsigned idx, int unsigned mult,
                                            int unsigned offs, int unsigned depth);
    return (idx * mult + offs) % depth;
  endfunction
endpackage

// File: rtl/dilv_wr_ctrl.sv
module dilv_wr_ctrl #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 64,
  localparam int AW  = $clog2(DEPTH),
  localparam int BLK = DEPTH * WORD_W,
  localparam int CW  = $clog2(BLK),
  localparam int PW  = $clog2(WORD_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_valid_i,
  input  logic          bit_i,
  input  logic          resync_i,
  input  logic          target_full_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wpos_o,
  output logic          wbit_o,
  output logic          wsel_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0]    cnt_q;
  logic             sel_q;
  logic [CW-AW-1:0] row;
  logic             last;

  assign row     = cnt_q[CW-1:AW];
  assign last    = (cnt_q == CW'(BLK - 1));
  assign we_o    = bit_valid_i && !resync_i && !target_full_i;
  assign waddr_o = cnt_q[AW-1:0];
  assign wpos_o  = PW'(WORD_W - 1) - PW'(row);
  assign wbit_o  = bit_i;
  assign wsel_o  = sel_q;
  assign done_o  = we_o && last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (resync_i) begin
      cnt_q <= '0;
    end else if (we_o) begin
      if (last) begin
        cnt_q <= '0;
        sel_q <= ~sel_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dilv_bank.sv
module dilv_bank #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [PW-1:0]     wpos_i,
  input  logic              wbit_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i][wpos_i] <= wbit_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dilv_rd_seq.sv
module dilv_rd_seq #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 64,
  parameter int MULT   = 37,
  parameter int OFFS   = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_strobe_i,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic              sel_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              block_start_o,
  output logic              ident_o
);
  import dilv_pkg::*;

  logic [AW-1:0] idx_q;
  logic          sel_q;
  logic          fire;

  assign fire    = rd_strobe_i && avail_i;
  assign raddr_o = AW'(perm_addr(int'(idx_q), MULT, OFFS, DEPTH));
  assign done_o  = fire && (idx_q == AW'(DEPTH - 1));
  assign sel_o   = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q         <= '0;
      sel_q         <= 1'b0;
      word_o        <= '0;
      word_valid_o  <= 1'b0;
      block_start_o <= 1'b0;
      ident_o       <= 1'b0;
    end else begin
      word_valid_o  <= fire;
      block_start_o <= fire && (idx_q == '0);
      if (fire) begin
        word_o  <= rdata_i;
        ident_o <= idx_q[0];
        idx_q   <= idx_q + 1'b1;
        if (done_o) sel_q <= ~sel_q;
      end
    end
  end
endmodule

// File: rtl/dilv_buffer.sv
module dilv_buffer #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 64,
  parameter int MULT   = 37,
  parameter int OFFS   = 11,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = $clog2(WORD_W),
  localparam int CW  = $clog2(DEPTH * WORD_W),
  localparam int NB  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              resync_i,
  input  logic              rd_strobe_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              block_start_o,
  output logic              ident_o
);
  logic [NB-1:0]     full_q;
  logic              we, wbit, wr_sel, wr_done;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wpos;
  logic [CW-1:0]     wr_cnt;
  logic              rd_sel, rd_done;
  logic [WORD_W-1:0] rdata [NB];

  dilv_wr_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_wr (
    .clk_i, .rst_ni, .bit_valid_i, .bit_i, .resync_i,
    .target_full_i(full_q[wr_sel]),
    .we_o(we), .waddr_o(waddr), .wpos_o(wpos), .wbit_o(wbit),
    .wsel_o(wr_sel), .done_o(wr_done), .cnt_o(wr_cnt)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    dilv_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
      .clk_i,
      .we_i(we && (wr_sel == 1'(b))),
      .waddr_i(waddr), .wpos_i(wpos), .wbit_i(wbit),
      .raddr_i(raddr), .rdata_o(rdata[b])
    );
  end

  dilv_rd_seq #(.WORD_W(WORD_W), .DEPTH(DEPTH), .MULT(MULT), .OFFS(OFFS)) u_rd (
    .clk_i, .rst_ni, .rd_strobe_i,
    .avail_i(full_q[rd_sel]), .rdata_i(rdata[rd_sel]),
    .raddr_o(raddr), .sel_o(rd_sel), .done_o(rd_done),
    .word_o, .word_valid_o, .block_start_o, .ident_o
  );

  // a bank is filled only when empty and read only when full: no set/clear clash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (wr_done && wr_sel == 1'(b)) full_q[b] <= 1'b1;
        else if (rd_done && rd_sel == 1'(b)) full_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dilv_checker.sv
module dilv_checker #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 64,
  localparam int CW = $clog2(DEPTH * WORD_W),
  localparam int KW = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              resync_i,
  input logic              rd_strobe_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              block_start_o,
  input logic              ident_o,
  input logic [1:0]        full_q,
  input logic [CW-1:0]     wr_cnt
);
  logic [KW-1:0] cnt_q;

  // words of the current block already emitted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (word_valid_o) cnt_q <= block_start_o ? KW'(1) : cnt_q + 1'b1;
  end

  p_valid_after_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(rd_strobe_i));
  p_start_with_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_start_o |-> word_valid_o);
  p_block_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !block_start_o) |-> (cnt_q != '0 && cnt_q < KW'(DEPTH)));
  p_ident_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (ident_o == (block_start_o ? 1'b0 : cnt_q[0])));
  p_idle_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && full_q == 2'b00) |=> !word_valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));
  p_resync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (wr_cnt == '0));
  p_no_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q == 2'b11) |=> $stable(wr_cnt));
endmodule

bind dilv_buffer dilv_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .resync_i(resync_i), .rd_strobe_i(rd_strobe_i),
  .word_o(word_o), .word_valid_o(word_valid_o), .block_start_o(block_start_o),
  .ident_o(ident_o), .full_q(full_q), .wr_cnt(wr_cnt)
);

// File: tb/sim_dilv_buffer.sv
`timescale 1ns/1ps
module sim_dilv_buffer;
  localparam int W = 11;
  localparam int D = 64;
  localparam int NT = 4;
  localparam int SEEDS [NT] = '{3, 17, 250, 999};
  localparam int GAPS  [NT] = '{0, 5, 0, 13};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bit_valid_i = 1'b0, bit_i = 1'b0, resync_i = 1'b0, rd_strobe_i = 1'b0;
  logic [W-1:0] word_o;
  logic word_valid_o, block_start_o, ident_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dilv_buffer u0 (.clk_i(clk), .rst_ni, .bit_valid_i, .bit_i, .resync_i, .rd_strobe_i,
                  .word_o, .word_valid_o, .block_start_o, .ident_o);

  function automatic logic [W-1:0] wv(int seed, int i);
    return W'((seed * 131 + i * 29 + 7 * i * i) & 'h7ff);
  endfunction

  function automatic int perm(int j);
    return (j * 37 + 11) % 64;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 bit placement, R11 gaps carry a junk bit with valid low
  task automatic stream(int seed, int gap, int nbits);
    for (int k = 0; k < nbits; k++) begin
      if (gap != 0 && k % gap == 0) begin
        @(negedge clk); bit_valid_i = 1'b0; bit_i = ~bit_i;
      end
      @(negedge clk);
      bit_valid_i = 1'b1;
      bit_i = wv(seed, k % D)[W - 1 - k / D];
    end
    @(negedge clk); bit_valid_i = 1'b0;
  endtask

  task automatic read_block(int seed);
    for (int j = 0; j < D; j++) begin
      @(negedge clk); rd_strobe_i = 1'b1;
      @(negedge clk); rd_strobe_i = 1'b0;
      chk(word_valid_o === 1'b1, "R4/R7 valid", int'(word_valid_o), 1);
      chk(word_o === wv(seed, perm(j)), "R2/R3 data", int'(word_o), int'(wv(seed, perm(j))));
      chk(block_start_o === (j == 0), "R5 start", int'(block_start_o), int'(j == 0));
      chk(ident_o === 1'(j & 1), "R6 ident", int'(ident_o), j & 1);
    end
    @(negedge clk);
    chk(word_valid_o === 1'b0, "R4 single", int'(word_valid_o), 0);
  endtask

  task automatic idle_strobe(string req);
    logic [W-1:0] prev;
    prev = word_o;
    @(negedge clk); rd_strobe_i = 1'b1;
    @(negedge clk); rd_strobe_i = 1'b0;
    chk(word_valid_o === 1'b0, req, int'(word_valid_o), 0);
    chk(word_o === prev, req, int'(word_o), int'(prev));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(word_valid_o === 1'b0 && block_start_o === 1'b0 && ident_o === 1'b0 && word_o === '0,
        "R1 reset", int'({word_valid_o, block_start_o, ident_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(word_valid_o === 1'b0 && word_o === '0, "R1 post-reset", int'(word_o), 0);

    idle_strobe("R8 empty");

    for (int t = 0; t < NT; t++) begin
      stream(SEEDS[t], GAPS[t], D * W);
      read_block(SEEDS[t]);
    end
    idle_strobe("R8 drained");

    // R7: last read of one bank on the same edge as the last bit of the other
    stream(41, 0, D * W);
    fork
      stream(42, 0, D * W);
      begin repeat (577) @(negedge clk); read_block(41); end
    join
    read_block(42);
    idle_strobe("R7 no extra block");

    // R10: both banks full, third block dropped
    stream(51, 0, D * W);
    stream(52, 0, D * W);
    stream(53, 7, D * W);
    read_block(51);
    read_block(52);
    idle_strobe("R10 dropped block");

    // R9: partial block discarded
    stream(77, 0, 300);
    @(negedge clk); resync_i = 1'b1;
    @(negedge clk); resync_i = 1'b0;
    idle_strobe("R9 partial hidden");
    stream(88, 3, D * W);
    read_block(88);
    idle_strobe("R9 nothing left");

    summary();
  end
endmodule